// File: doc/BRIEF.md
# Host Command Word Decoder

This block sits behind the serial receiver of a voice-band converter front end and interprets each 16-bit word that the host processor sends. A word arrives in one of two kinds. The normal kind (a primary word) carries a 14-bit sample for the DAC in its upper bits and a two-bit timing adjust code in its lowest bits. That code asks for no change, for the trim value to be added to the next period, or for it to be subtracted. One code value also announces that the following word is a secondary word. A secondary word does not carry a sample. It uses its two lowest bits to choose a destination: the divider-A pair, the trim pair, the divider-B pair, or the control flags.

Values written by secondary words go first into shadow registers. They reach the outputs seen by the counters only when the matching counter reloads, so a period that has already started keeps its settings. The control flags are decoded onto separate outputs. When loopback is active, the word returned toward the host in place of the ADC result is the current DAC sample with its two low bits zero.

Top module: `host_word_decoder`

## Requirements
- R1: After reset the divider-A outputs read 9, the trim outputs read 1 and the divider-B outputs read 36 on both paths. High-pass, sync mode and sin(x)/x are 1, gain is 2'b11, loopback and auxiliary select are 0, sec_req is 0 and adj_stb is 0.
- R2: A primary word puts bits 15:2 on dac_data and bits 1:0 on adj_code one cycle after word_valid, and adj_stb is high for exactly that cycle. The adj_code values are 00 none, 01 add trim, 10 subtract trim, and 11 none with a secondary request.
- R3: A primary word with bits 1:0 = 11 raises sec_req in the next cycle. The next accepted word is then decoded as a secondary word, whatever its low bits are, and sec_req is low in the cycle after it.
- R4: A secondary word with bits 1:0 = 00 loads the transmit divider A from bits 13:9 and the receive divider A from bits 6:2, both unsigned.
- R5: A secondary word with bits 1:0 = 01 loads the transmit trim from bits 14:9 and the receive trim from bits 7:2. Both are two's complement, with the sign in bit 14 and bit 7 respectively.
- R6: A secondary word with bits 1:0 = 10 loads the transmit divider B from bits 14:9 and the receive divider B from bits 7:2, both unsigned.
- R7: A secondary word with bits 1:0 = 11 loads the control flags: bit 2 high-pass, bit 3 loopback, bit 4 auxiliary input, bit 5 sync mode, bits 7:6 gain, bit 9 sin(x)/x.
- R8: A written value appears on an output only in the cycle after the matching reload strobe. Transmit fields and the control flags follow tx_reload; receive fields follow rx_reload. Without that strobe the output stays unchanged.
- R9: A secondary word leaves dac_data unchanged and does not pulse adj_stb.
- R10: While loopback is active, adc_out equals {dac_data, 2'b00}; otherwise adc_out equals adc_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | A received host word is present on word_in |
| word_in | input | 16 | Received host word |
| tx_reload | input | 1 | Transmit counter reload strobe |
| rx_reload | input | 1 | Receive counter reload strobe |
| adc_in | input | 16 | Converter result word |
| dac_data | output | 14 | Latest DAC sample |
| adj_code | output | 2 | Timing adjust code of the latest primary word |
| adj_stb | output | 1 | One-cycle pulse after each primary word |
| sec_req | output | 1 | Next word is secondary |
| tx_a | output | 5 | Active transmit divider A |
| tx_trim | output | 6 | Active transmit trim, signed |
| tx_b | output | 6 | Active transmit divider B |
| rx_a | output | 5 | Active receive divider A |
| rx_trim | output | 6 | Active receive trim, signed |
| rx_b | output | 6 | Active receive divider B |
| hp_en | output | 1 | High-pass filter inserted |
| loop_en | output | 1 | Loopback active |
| aux_sel | output | 1 | Auxiliary inputs selected |
| sync_mode | output | 1 | Transmit and receive synchronous |
| gain | output | 2 | Input gain code |
| sinx_en | output | 1 | sin(x)/x filter inserted |
| adc_out | output | 16 | Word returned to the host |

## Verification
The hardest state to reach is a freshly written shadow value that is waiting while only one of the two reload strobes fires. At that point the transmit half must show the new value and the receive half must still show the old one. Each secondary sweep step therefore writes different values to the two paths, then checks the outputs three times: before any reload, after a transmit-only reload, and after a receive-only reload. Before each secondary word the bench sends a primary word with code 11 and a sample that differs every step. This exercises the word-type tracking flag and shows that the secondary word leaves the sample alone. The control sweep covers all 128 flag combinations, and the loopback return path is checked whenever loopback is active.

// File: rtl/host_word_decoder.sv
module host_word_decoder #(
  parameter logic [4:0] A_RST    = 5'd9,
  parameter logic [5:0] TRIM_RST = 6'd1,
  parameter logic [5:0] B_RST    = 6'd36,
  parameter logic [6:0] CTRL_RST = 7'b1_11_1_0_0_1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        word_valid,
  input  logic [15:0] word_in,
  input  logic        tx_reload,
  input  logic        rx_reload,
  input  logic [15:0] adc_in,
  output logic [13:0] dac_data,
  output logic [1:0]  adj_code,
  output logic        adj_stb,
  output logic        sec_req,
  output logic [4:0]  tx_a,
  output logic [5:0]  tx_trim,
  output logic [5:0]  tx_b,
  output logic [4:0]  rx_a,
  output logic [5:0]  rx_trim,
  output logic [5:0]  rx_b,
  output logic        hp_en,
  output logic        loop_en,
  output logic        aux_sel,
  output logic        sync_mode,
  output logic [1:0]  gain,
  output logic        sinx_en,
  output logic [15:0] adc_out
);

  logic       sec_pend;
  logic [4:0] tx_a_s, rx_a_s;
  logic [5:0] tx_trim_s, rx_trim_s, tx_b_s, rx_b_s;
  logic [6:0] ctrl_s, ctrl_q;

  wire is_pri = word_valid & ~sec_pend;
  wire is_sec = word_valid &  sec_pend;
  wire [1:0] sel = word_in[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_pend <= 1'b0;
      dac_data <= '0;
      adj_code <= 2'b00;
      adj_stb  <= 1'b0;
    end else begin
      adj_stb <= is_pri;
      if (is_pri) begin
        dac_data <= word_in[15:2];
        adj_code <= sel;
        sec_pend <= (sel == 2'b11);
      end else if (is_sec) begin
        sec_pend <= 1'b0;
      end
    end
  end

  assign sec_req = sec_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_a_s    <= A_RST;
      rx_a_s    <= A_RST;
      tx_trim_s <= TRIM_RST;
      rx_trim_s <= TRIM_RST;
      tx_b_s    <= B_RST;
      rx_b_s    <= B_RST;
      ctrl_s    <= CTRL_RST;
    end else if (is_sec) begin
      case (sel)
        2'b00: begin
          tx_a_s <= word_in[13:9];
          rx_a_s <= word_in[6:2];
        end
        2'b01: begin
          tx_trim_s <= word_in[14:9];
          rx_trim_s <= word_in[7:2];
        end
        2'b10: begin
          tx_b_s <= word_in[14:9];
          rx_b_s <= word_in[7:2];
        end
        default: ctrl_s <= {word_in[9], word_in[7:2]};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_a    <= A_RST;
      tx_trim <= TRIM_RST;
      tx_b    <= B_RST;
      ctrl_q  <= CTRL_RST;
    end else if (tx_reload) begin
      tx_a    <= tx_a_s;
      tx_trim <= tx_trim_s;
      tx_b    <= tx_b_s;
      ctrl_q  <= ctrl_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_a    <= A_RST;
      rx_trim <= TRIM_RST;
      rx_b    <= B_RST;
    end else if (rx_reload) begin
      rx_a    <= rx_a_s;
      rx_trim <= rx_trim_s;
      rx_b    <= rx_b_s;
    end
  end

  assign hp_en     = ctrl_q[0];
  assign loop_en   = ctrl_q[1];
  assign aux_sel   = ctrl_q[2];
  assign sync_mode = ctrl_q[3];
  assign gain      = ctrl_q[5:4];
  assign sinx_en   = ctrl_q[6];

  assign adc_out = loop_en ? {dac_data, 2'b00} : adc_in;

  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_reload |=> ($stable(tx_a) && $stable(tx_trim) && $stable(tx_b) && $stable(ctrl_q)));

  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_reload |=> ($stable(rx_a) && $stable(rx_trim) && $stable(rx_b)));

  // R3
  sec_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !sec_req && word_in[1:0] == 2'b11) |=> sec_req);

  // R3
  sec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && sec_req) |=> !sec_req);

  // R9
  sec_keeps_dac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && sec_req) |=> ($stable(dac_data) && !adj_stb));

  // R2
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !sec_req) |=> adj_stb);

endmodule

// File: tb/host_word_decoder_tb.sv
module host_word_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic word_valid = 1'b0;
  logic [15:0] word_in = '0;
  logic tx_reload = 1'b0, rx_reload = 1'b0;
  logic [15:0] adc_in = 16'h1234;
  logic [13:0] dac_data;
  logic [1:0]  adj_code, gain;
  logic adj_stb, sec_req, hp_en, loop_en, aux_sel, sync_mode, sinx_en;
  logic [4:0] tx_a, rx_a;
  logic [5:0] tx_trim, rx_trim, tx_b, rx_b;
  logic [15:0] adc_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  host_word_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_in(word_in),
    .tx_reload(tx_reload), .rx_reload(rx_reload), .adc_in(adc_in),
    .dac_data(dac_data), .adj_code(adj_code), .adj_stb(adj_stb), .sec_req(sec_req),
    .tx_a(tx_a), .tx_trim(tx_trim), .tx_b(tx_b), .rx_a(rx_a), .rx_trim(rx_trim), .rx_b(rx_b),
    .hp_en(hp_en), .loop_en(loop_en), .aux_sel(aux_sel), .sync_mode(sync_mode),
    .gain(gain), .sinx_en(sinx_en), .adc_out(adc_out)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] w);
    @(negedge clk); word_valid = 1'b1; word_in = w;
    @(negedge clk); word_valid = 1'b0; word_in = '0;
  endtask

  task automatic rl(input bit t, input bit r);
    @(negedge clk); tx_reload = t; rx_reload = r;
    @(negedge clk); tx_reload = 1'b0; rx_reload = 1'b0;
  endtask

  logic [13:0] e_dac;
  logic [4:0]  e_txa, e_rxa;
  logic [5:0]  e_txt, e_rxt, e_txb, e_rxb;
  logic [6:0]  e_ctl;

  task automatic chk_regs(input string req);
    chk(req, "tx_a", tx_a, e_txa);
    chk(req, "rx_a", rx_a, e_rxa);
    chk(req, "tx_trim", tx_trim, e_txt);
    chk(req, "rx_trim", rx_trim, e_rxt);
    chk(req, "tx_b", tx_b, e_txb);
    chk(req, "rx_b", rx_b, e_rxb);
    chk(req, "ctrl", {sinx_en, gain, sync_mode, aux_sel, loop_en, hp_en}, e_ctl);
  endtask

  task automatic open_sec(input logic [13:0] d);
    put({d, 2'b11});
    e_dac = d;
    chk("R3", "sec_req set", sec_req, 1);
    chk("R2", "dac on code 11", dac_data, d);
  endtask

  task automatic after_sec();
    chk("R3", "sec_req cleared", sec_req, 0);
    chk("R9", "dac kept", dac_data, e_dac);
    chk("R9", "no adj_stb", adj_stb, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    e_dac = '0; e_txa = 5'd9; e_rxa = 5'd9; e_txt = 6'd1; e_rxt = 6'd1;
    e_txb = 6'd36; e_rxb = 6'd36; e_ctl = 7'b1111001;
    chk_regs("R1");
    chk("R1", "sec_req", sec_req, 0);
    chk("R1", "adj_stb", adj_stb, 0);
    chk("R10", "adc passthrough", adc_out, adc_in);

    // R2: primary words, codes 00/01/10
    for (int i = 0; i < 192; i++) begin
      logic [15:0] w;
      w = {16'(i * 16'h0153 + 16'h2A7)} & 16'hFFFC;
      w[1:0] = 2'(i % 3);
      put(w);
      e_dac = w[15:2];
      chk("R2", "dac_data", dac_data, w[15:2]);
      chk("R2", "adj_code", adj_code, w[1:0]);
      chk("R2", "adj_stb high", adj_stb, 1);
      chk("R3", "no sec_req", sec_req, 0);
      @(negedge clk);
      chk("R2", "adj_stb one cycle", adj_stb, 0);
    end

    // R4 divider A
    for (int v = 0; v < 32; v++) begin
      logic [4:0] t, r;
      t = 5'(v); r = 5'(31 - v);
      open_sec(14'(v * 97 + 5));
      put({2'b00, t, 2'b00, r, 2'b00});
      after_sec();
      chk_regs("R8");
      rl(1, 0); e_txa = t; chk_regs("R4");
      rl(0, 1); e_rxa = r; chk_regs("R4");
    end

    // R5 trim, signed
    for (int v = 0; v < 64; v++) begin
      logic [5:0] t, r;
      t = 6'(v); r = 6'(63 - v);
      open_sec(14'(v * 211 + 3));
      put({1'b0, t, 1'b0, r, 2'b01});
      after_sec();
      chk_regs("R8");
      rl(1, 0); e_txt = t; chk_regs("R5");
      chk("R5", "tx trim sign", ($signed(tx_trim) < 0), t[5]);
      rl(0, 1); e_rxt = r; chk_regs("R5");
      chk("R5", "rx trim sign", ($signed(rx_trim) < 0), r[5]);
    end

    // R6 divider B
    for (int v = 0; v < 64; v++) begin
      logic [5:0] t, r;
      t = 6'(63 - v); r = 6'(v);
      open_sec(14'(v * 45 + 11));
      put({1'b0, t, 1'b0, r, 2'b10});
      after_sec();
      chk_regs("R8");
      rl(0, 1); e_rxb = r; chk_regs("R6");
      rl(1, 0); e_txb = t; chk_regs("R6");
    end

    // R7 control, R10 loopback
    for (int c = 0; c < 128; c++) begin
      logic [6:0] cb;
      cb = 7'(c ^ 7'h55);
      adc_in = 16'h5A5A ^ 16'(c * 257);
      open_sec(14'(c * 131 + 7));
      put({6'b0, cb[6], 1'b0, cb[5:0], 2'b11});
      after_sec();
      chk_regs("R8");
      rl(0, 1); chk_regs("R8");
      rl(1, 0); e_ctl = cb; chk_regs("R7");
      chk("R10", "adc_out", adc_out, cb[1] ? {e_dac, 2'b00} : adc_in);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule